// File: doc/BRIEF.md
# Power-of-Two Up/Down Loop Counter

This block is the loop-filter counter of a first-order digital phase-locked loop. It counts up or down once per strobe on a K-clock enable, with the direction taken from a phase-detector output. When the count passes its top value going up, it raises a one-cycle carry pulse. When it passes zero going down, it raises a one-cycle borrow pulse. The carry and borrow pulses drive a pulse add/delete stage further along the loop.

The modulus is a power of two picked by a 4-bit code: code n (1 to 15) gives a modulus of 2^(n+2), so from 8 up to 131072. Code 0 stops the counter. A large modulus gives a narrow loop bandwidth and slow lock. A small modulus gives a wide bandwidth and fast lock. The code can be changed while the counter is running, so the bandwidth can be tuned while the loop operates. On a change of code, the count is cut down to the new width and counting goes on without a restart. All inputs are synchronous to the system clock. Any strobe from another clock domain must be brought in before it reaches this block.

Top module: `kloop_counter`

## Requirements
- R1: A synchronous active-low reset clears the count to zero and holds carry_pulse and borrow_pulse low. After reset, the first carry comes on exactly the 2^(n+2)-th up step, and the first borrow comes on the first down step.
- R2: While mod_code is 0, no step changes the count and no carry or borrow is produced. The count held beforehand is kept.
- R3: For mod_code n from 1 to 15, the counter has 2^(n+2) states. Counting up from zero produces a carry on every 2^(n+2)-th step and never in between. This holds for n = 1, 2, 5 and 15.
- R4: A carry is produced by the up step that moves the count from its top value (2^(n+2)-1) back to zero. carry_pulse is high during the one clock cycle right after the clock edge that takes that step.
- R5: A borrow is produced by the down step that moves the count from zero to its top value. borrow_pulse is high during the one clock cycle right after the clock edge that takes that step.
- R6: dir_down is sampled on step cycles. A value of 1 counts down and a value of 0 counts up. An up step never produces a borrow and a down step never produces a carry. Up steps followed by the same number of down steps return the count to its starting value.
- R7: A step is taken only on a clock edge where k_step and cnt_en are both 1. On any other edge the count does not change, and no carry or borrow follows.
- R8: When mod_code changes to a smaller modulus, the count keeps only its low n+2 bits and goes on counting without a reset. For example, a count of 10 at modulus 16 becomes 2 at modulus 8, and the carry then comes on the 6th up step.
- R9: carry_pulse and borrow_pulse are never high in the same cycle. With a step on every clock edge, neither pulse stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| k_step | input | 1 | K-clock enable strobe, one step per high cycle |
| cnt_en | input | 1 | Count enable, sampled together with k_step |
| dir_down | input | 1 | Direction: 1 counts down, 0 counts up |
| mod_code | input | 4 | Modulus code: 0 inhibits, n selects 2^(n+2) |
| carry_pulse | output | 1 | One-cycle pulse on an up wrap |
| borrow_pulse | output | 1 | One-cycle pulse on a down wrap |

## Verification
The bench counts pulses over long runs of steps at several codes, including the full 131072-step cycle of code 15. A mask decoder that is off by one stage would put the carry at half or double the expected step count.

The bench also:
- Parks the counter under code 0 and under a low enable, then checks that the wrap point afterwards has not moved. A design that leaked steps in either state would carry early.
- Narrows the modulus in the middle of a count. A design that reset the count on a code change would carry two steps late.
- Reverses direction and checks for a down wrap straight after reset. A design whose wrap compare does not distinguish direction would give a missing or misplaced borrow.

// File: rtl/kloop_pkg.sv
// Shared sizing for the power-of-two loop counter.
// Assumes the modulus code width sets the deepest counter:
// the largest code plus the fixed base stage count.
package kloop_pkg;
    localparam int KL_CODE_W      = 4;
    localparam int KL_BASE_STAGES = 2;

    // Number of count bits needed for the largest code.
    function automatic int kl_state_width(input int code_w, input int base);
        return (1 << code_w) - 1 + base;
    endfunction
endpackage

// File: rtl/kloop_mask_dec.sv
// Turns a modulus code into a bit mask over the count register.
// Bit i is set when code is non-zero and i < code + BASE_STAGES.
// Assumes STATE_W covers the largest code; code 0 gives an all-zero mask.
module kloop_mask_dec #(
    parameter int CODE_W      = 4,
    parameter int BASE_STAGES = 2,
    parameter int STATE_W     = 17
) (
    input  logic [CODE_W-1:0]  code,
    output logic [STATE_W-1:0] mask,
    output logic               active
);
    localparam int CODE_MAX = (1 << CODE_W) - 1;

    // active: any non-zero code lets the counter run
    assign active = (code != '0);

    // One enable bit per count stage
    for (genvar i = 0; i < STATE_W; i++) begin : g_stage
        assign mask[i] = active && ((int'(code) + BASE_STAGES) > i);
    end

    // Static check that the register is wide enough for the top code
    if (STATE_W < CODE_MAX + BASE_STAGES) begin : g_bad_width
        initial $error("kloop_mask_dec: STATE_W too small for CODE_W");
    end
endmodule

// File: rtl/kloop_count_core.sv
// Up/down count register, limited to the stages selected by a mask.
// A step is taken when step_ok is high. The value is re-masked on every
// step, so narrowing the mask keeps only the low bits of the old value.
// Assumes the mask is contiguous from bit 0 whenever step_ok is high.
module kloop_count_core #(
    parameter int STATE_W = 17
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step_ok,
    input  logic               go_down,
    input  logic [STATE_W-1:0] mask,
    output logic               wrap_up,
    output logic               wrap_down
);
    logic [STATE_W-1:0] cnt_q;
    logic [STATE_W-1:0] cnt_eff;
    logic [STATE_W-1:0] cnt_nxt;

    // Wrap detection and next value from the masked count
    always_comb begin
        cnt_eff   = cnt_q & mask;
        wrap_up   = step_ok && !go_down && (cnt_eff == mask);
        wrap_down = step_ok &&  go_down && (cnt_eff == '0);
        if (go_down) begin
            cnt_nxt = (cnt_eff - 1'b1) & mask;
        end else begin
            cnt_nxt = (cnt_eff + 1'b1) & mask;
        end
    end

    // Count register: cleared on reset, updated only on accepted steps
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (step_ok) begin
            cnt_q <= cnt_nxt;
        end
    end
endmodule

// File: rtl/kloop_pulse_reg.sv
// Registers the wrap flags into one-cycle carry and borrow pulses.
// Assumes each wrap flag is high for at most the one cycle of its step.
module kloop_pulse_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap_up,
    input  logic wrap_down,
    output logic carry_q,
    output logic borrow_q
);
    // Output registers: each pulse follows the step edge by one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carry_q  <= 1'b0;
            borrow_q <= 1'b0;
        end else begin
            carry_q  <= wrap_up;
            borrow_q <= wrap_down;
        end
    end
endmodule

// File: rtl/kloop_counter.sv
// Top of the programmable power-of-two up/down loop counter.
// Counts on clock edges where k_step and cnt_en are both high, upward when
// dir_down is low. Gives one-cycle carry/borrow pulses on wraps.
// Code 0 inhibits counting.
// Assumes all inputs are synchronous to clk.
module kloop_counter
    import kloop_pkg::*;
#(
    parameter int CODE_W      = KL_CODE_W,
    parameter int BASE_STAGES = KL_BASE_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              k_step,
    input  logic              cnt_en,
    input  logic              dir_down,
    input  logic [CODE_W-1:0] mod_code,
    output logic              carry_pulse,
    output logic              borrow_pulse
);
    localparam int STATE_W = kl_state_width(CODE_W, BASE_STAGES);

    logic [STATE_W-1:0] stage_mask;
    logic               code_active;
    logic               step_ok;
    logic               wrap_up;
    logic               wrap_down;

    kloop_mask_dec #(
        .CODE_W      (CODE_W),
        .BASE_STAGES (BASE_STAGES),
        .STATE_W     (STATE_W)
    ) u_mask (
        .code   (mod_code),
        .mask   (stage_mask),
        .active (code_active)
    );

    // step_ok: strobe, enable and a non-zero code all required
    assign step_ok = k_step && cnt_en && code_active;

    kloop_count_core #(
        .STATE_W (STATE_W)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_ok   (step_ok),
        .go_down   (dir_down),
        .mask      (stage_mask),
        .wrap_up   (wrap_up),
        .wrap_down (wrap_down)
    );

    kloop_pulse_reg u_pulse (
        .clk       (clk),
        .rst_n     (rst_n),
        .wrap_up   (wrap_up),
        .wrap_down (wrap_down),
        .carry_q   (carry_pulse),
        .borrow_q  (borrow_pulse)
    );
endmodule

// File: rtl/kloop_counter_chk.sv
// Port-level property checker for kloop_counter, attached by bind.
// Assumes the synchronous active-low reset of the top module.
module kloop_counter_chk #(
    parameter int CODE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              k_step,
    input logic              cnt_en,
    input logic              dir_down,
    input logic [CODE_W-1:0] mod_code,
    input logic              carry_pulse,
    input logic              borrow_pulse
);
    // R1: reset edge leaves both pulses low
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!carry_pulse && !borrow_pulse));

    // R2: code 0 makes the next cycle pulse-free
    assert_inhibit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_code == '0) |=> (!carry_pulse && !borrow_pulse));

    // R7: no accepted step means no pulse next cycle
    assert_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!k_step || !cnt_en) |=> (!carry_pulse && !borrow_pulse));

    // R6: up step never borrows
    assert_up_no_borrow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (k_step && !dir_down) |=> !borrow_pulse);

    // R6: down step never carries
    assert_down_no_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (k_step && dir_down) |=> !carry_pulse);

    // R9: carry and borrow are exclusive
    assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(carry_pulse && borrow_pulse));

    // R9: each pulse lasts one cycle
    assert_carry_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        carry_pulse |=> !carry_pulse);

    assert_borrow_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        borrow_pulse |=> !borrow_pulse);
endmodule

bind kloop_counter kloop_counter_chk #(.CODE_W(CODE_W)) u_kloop_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .k_step       (k_step),
    .cnt_en       (cnt_en),
    .dir_down     (dir_down),
    .mod_code     (mod_code),
    .carry_pulse  (carry_pulse),
    .borrow_pulse (borrow_pulse)
);

// File: tb/test_kloop_counter.sv
module test_kloop_counter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       k_step = 1'b0;
    logic       cnt_en = 1'b0;
    logic       dir_down = 1'b0;
    logic [3:0] mod_code = 4'd0;
    logic       carry_pulse;
    logic       borrow_pulse;

    int checks = 0;
    int errors = 0;
    int n_carry, n_borrow, first_c, first_b, last_c;
    bit both_seen, long_seen;

    kloop_counter i_kloop_counter (
        .clk          (clk),
        .rst_n        (rst_n),
        .k_step       (k_step),
        .cnt_en       (cnt_en),
        .dir_down     (dir_down),
        .mod_code     (mod_code),
        .carry_pulse  (carry_pulse),
        .borrow_pulse (borrow_pulse)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; k_step = 1'b0; cnt_en = 1'b0; dir_down = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Strobe on n consecutive edges; sample i reflects step i
    task automatic burst(input int n, input bit dn, input bit en);
        bit prev_c, prev_b;
        n_carry = 0; n_borrow = 0; first_c = 0; first_b = 0; last_c = 0;
        both_seen = 0; long_seen = 0; prev_c = 0; prev_b = 0;
        @(negedge clk);
        k_step = 1'b1; dir_down = dn; cnt_en = en;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            if (carry_pulse) begin
                n_carry++; last_c = i;
                if (first_c == 0) first_c = i;
            end
            if (borrow_pulse) begin
                n_borrow++;
                if (first_b == 0) first_b = i;
            end
            if (carry_pulse && borrow_pulse) both_seen = 1;
            if ((carry_pulse && prev_c) || (borrow_pulse && prev_b)) long_seen = 1;
            prev_c = carry_pulse; prev_b = borrow_pulse;
        end
        k_step = 1'b0;
        @(negedge clk);
        if (carry_pulse || borrow_pulse) long_seen = 1;
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        check("R1 carry after reset", carry_pulse, 0);
        check("R1 borrow after reset", borrow_pulse, 0);
    endtask

    task automatic t_modulus(input int code);
        int m;
        m = 1 << (code + 2);
        do_reset();
        mod_code = 4'(code);
        burst(m - 1, 1'b0, 1'b1);
        check($sformatf("R3 code %0d carries before wrap", code), n_carry, 0);
        burst(1, 1'b0, 1'b1);
        check($sformatf("R1 R4 code %0d carry on step m", code), first_c, 1);
    endtask

    task automatic t_repeat();
        do_reset();
        mod_code = 4'd1;
        burst(24, 1'b0, 1'b1);
        check("R3 carries in 24 steps", n_carry, 3);
        check("R4 first carry index", first_c, 8);
        check("R4 last carry index", last_c, 24);
        check("R9 no overlap", both_seen, 0);
        check("R9 single cycle pulses", long_seen, 0);
    endtask

    task automatic t_inhibit();
        do_reset();
        mod_code = 4'd1;
        burst(3, 1'b0, 1'b1);
        mod_code = 4'd0;
        burst(40, 1'b0, 1'b1);
        check("R2 no carry with code 0", n_carry, 0);
        burst(40, 1'b1, 1'b1);
        check("R2 no borrow with code 0", n_borrow, 0);
        mod_code = 4'd1;
        burst(5, 1'b0, 1'b1);
        check("R2 count held under code 0", first_c, 5);
    endtask

    task automatic t_down();
        do_reset();
        mod_code = 4'd1;
        burst(1, 1'b1, 1'b1);
        check("R1 R5 borrow on first down step", n_borrow, 1);
        check("R6 down step no carry", n_carry, 0);
        burst(8, 1'b1, 1'b1);
        check("R5 next borrow at step 8", first_b, 8);
        check("R5 one borrow in 8", n_borrow, 1);
    endtask

    task automatic t_enable();
        do_reset();
        mod_code = 4'd1;
        burst(4, 1'b0, 1'b1);
        burst(20, 1'b0, 1'b0);
        burst(20, 1'b1, 1'b0);
        check("R7 no pulse with enable low", n_carry + n_borrow, 0);
        cnt_en = 1'b1; dir_down = 1'b1;
        repeat (10) @(negedge clk);
        burst(4, 1'b0, 1'b1);
        check("R7 count frozen: carry on 4th", first_c, 4);
    endtask

    task automatic t_trunc();
        do_reset();
        mod_code = 4'd2;
        burst(10, 1'b0, 1'b1);
        check("R8 no carry before shrink", n_carry, 0);
        mod_code = 4'd1;
        burst(6, 1'b0, 1'b1);
        check("R8 carry on 6th step after shrink", first_c, 6);
    endtask

    task automatic t_reverse();
        do_reset();
        mod_code = 4'd3;
        burst(5, 1'b0, 1'b1);
        burst(5, 1'b1, 1'b1);
        check("R6 no pulse on return", n_borrow + n_carry, 0);
        burst(1, 1'b1, 1'b1);
        check("R6 borrow after return to zero", n_borrow, 1);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_modulus(1);
                t_modulus(2);
                t_modulus(5);
                t_repeat();
                t_inhibit();
                t_down();
                t_enable();
                t_trunc();
                t_reverse();
                t_modulus(15);
            end
            begin
                repeat (199000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog actual timeout expected completion");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule